// File: doc/BRIEF.md
# Keyed Index/Data Configuration Register File

This block is the configuration space of a multi-function host-bus peripheral. The host reaches it through two 8-bit ports that share one bus: an index port, which holds a register number, and a data port, which reads or writes the register that number points at. Every access has the same two steps. The host writes the register number to the index port. It then reads or writes the value through the data port.

The space starts out locked. It opens only after the host writes the enter key to the index port on two consecutive writes. It locks again on one write of the exit key. The global registers give a 16-bit chip identity and a 16-bit vendor identity, each split into a high byte and a low byte, plus a selector that picks one logical device. Each logical device has its own bank: an enable bit, a 16-bit I/O base split into two bytes, and an interrupt line number. The bank the selector points at sits behind a fixed set of register numbers.

The block drives the enable, base and interrupt number of every logical device on plain output pins, so that neighbouring decoders can claim their I/O windows. Host accesses are single-cycle strobes. There is no back-pressure: a write takes effect on the clock edge where its strobe is high, and read data is valid in the same cycle as the read strobe.

Top module: `cfgport_top`

## Requirements
- R1: The space opens only after two consecutive index-port writes of the enter key (default 0x87). After a single key write, every read still returns 0xFF. Reads between the two key writes do not break the sequence.
- R2: While the space is locked, any other write breaks the unlock sequence, and the next enter key counts as the first again. This covers an index write of any other value and any data-port write.
- R3: While the space is open, one index-port write of the exit key (default 0xAA) locks it. That write does not change the stored register number.
- R4: While the space is locked, every read of either port returns 0xFF, and data-port writes change no register. When no read is strobed, host_rdata is 0xFF.
- R5: While the space is open, an index-port write stores the register number. An index-port read returns that number. Data-port accesses go to that register.
- R6: Register 0x20 returns the chip identity high byte and 0x21 the low byte. Register 0x22 returns the vendor identity high byte and 0x23 the low byte. All four are read-only, and writes to them are ignored.
- R7: Register 0x07 is the logical-device selector. It stores all 8 written bits and reads them back. It picks the bank that registers 0x30, 0x60, 0x61 and 0x70 reach.
- R8: The bank registers are laid out as follows. 0x30 is the enable: bit 0 only, other bits read 0. 0x60 is the base high byte. 0x61 is the base low byte. 0x70 is the interrupt number: the low IRQ_W bits, zero-extended on read. Device i drives dev_enable[i], dev_base[16*i +: 16] and dev_irq[IRQ_W*i +: IRQ_W] from its bank.
- R9: After reset the space is locked, and the stored register number and the selector are 0x00. Every bank is disabled, with base 0x0000 and interrupt number 0.
- R10: A read-modify-write of one register changes only the bits written to it. The other byte of the base and the banks of the other devices are left unchanged.
- R11: If the selector value is NUM_LDEV or higher, bank register reads return 0x00 and bank writes are ignored. Any register number without a mapping reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe; data is valid in the same cycle |
| host_port | input | 1 | 0 selects the index port, 1 selects the data port |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data; 0xFF when locked or when no read is strobed |
| dev_enable | output | NUM_LDEV | Enable of each logical device |
| dev_base | output | 16*NUM_LDEV | I/O base of each logical device |
| dev_irq | output | IRQ_W*NUM_LDEV | Interrupt number of each logical device |

## Verification
A table of accesses opens the space and reads every identity byte. It writes the selector and one full bank, and reads each value back; this separates correct register decoding from aliasing between register numbers. Directed sequences follow. They try key patterns that must not open the space: a single key, a key followed by a foreign index value, and a key followed by a data write. They also check that a key pair with a read between the two writes does open it, which separates a true two-in-a-row detector from one that counts keys or is reset by reads. Further cases cover a read-modify-write on the base low byte, an out-of-range selector, and writes while locked. Each is checked against every device output, so that a stray write into the wrong bank or byte shows up.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_ARMED  = 2'd1,
    ST_OPEN   = 2'd2
  } lock_st_t;

  // register numbers the host software relies on
  localparam logic [7:0] RN_LDSEL   = 8'h07;
  localparam logic [7:0] RN_CHIP_HI = 8'h20;
  localparam logic [7:0] RN_CHIP_LO = 8'h21;
  localparam logic [7:0] RN_VEND_HI = 8'h22;
  localparam logic [7:0] RN_VEND_LO = 8'h23;
  localparam logic [7:0] RN_DEV_EN  = 8'h30;
  localparam logic [7:0] RN_BASE_HI = 8'h60;
  localparam logic [7:0] RN_BASE_LO = 8'h61;
  localparam logic [7:0] RN_IRQ     = 8'h70;

  localparam logic [7:0] RD_FLOAT   = 8'hFF;

endpackage

// File: rtl/cfgport_unlock.sv
module cfgport_unlock
  import cfgport_pkg::*;
#(
  parameter logic [7:0] KEY_ENTER = 8'h87,
  parameter logic [7:0] KEY_EXIT  = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       dat_wr,
  input  logic [7:0] wdata,
  output logic       cfg_open
);

  lock_st_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_LOCKED: if (idx_wr && wdata == KEY_ENTER) state_d = ST_ARMED;
      ST_ARMED: begin
        if (idx_wr) state_d = (wdata == KEY_ENTER) ? ST_OPEN : ST_LOCKED;
        else if (dat_wr) state_d = ST_LOCKED;
      end
      ST_OPEN: if (idx_wr && wdata == KEY_EXIT) state_d = ST_LOCKED;
      default: state_d = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_LOCKED;
    else        state_q <= state_d;
  end

  assign cfg_open = (state_q == ST_OPEN);

  // R1
  single_key_no_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCKED) |=> !cfg_open);

  // R2
  broken_seq_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED && !idx_wr && dat_wr) |=> (state_q == ST_LOCKED));

  // R3
  exit_key_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && idx_wr && wdata == KEY_EXIT) |=> !cfg_open);

endmodule

// File: rtl/cfgport_global.sv
module cfgport_global
  import cfgport_pkg::*;
#(
  parameter logic [15:0] CHIP_ID   = 16'h1A2B,
  parameter logic [15:0] VENDOR_ID = 16'h3C4D,
  parameter logic [7:0]  KEY_EXIT  = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_open,
  input  logic       idx_wr,
  input  logic       dat_wr,
  input  logic [7:0] wdata,
  output logic [7:0] idx_q,
  output logic [7:0] ldsel_q,
  output logic       glob_hit,
  output logic [7:0] glob_rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= 8'h00;
      ldsel_q <= 8'h00;
    end else if (cfg_open) begin
      if (idx_wr && wdata != KEY_EXIT) idx_q <= wdata;
      if (dat_wr && idx_q == RN_LDSEL) ldsel_q <= wdata;
    end
  end

  always_comb begin
    glob_hit   = 1'b1;
    glob_rdata = 8'h00;
    case (idx_q)
      RN_LDSEL:   glob_rdata = ldsel_q;
      RN_CHIP_HI: glob_rdata = CHIP_ID[15:8];
      RN_CHIP_LO: glob_rdata = CHIP_ID[7:0];
      RN_VEND_HI: glob_rdata = VENDOR_ID[15:8];
      RN_VEND_LO: glob_rdata = VENDOR_ID[7:0];
      default:    glob_hit   = 1'b0;
    endcase
  end

  // R3
  exit_keeps_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && wdata == KEY_EXIT) |=> $stable(idx_q));

  // R4
  locked_selector_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable(ldsel_q));

endmodule

// File: rtl/cfgport_bank.sv
module cfgport_bank
  import cfgport_pkg::*;
#(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_sel,
  input  logic [7:0]       reg_num,
  input  logic [7:0]       wdata,
  output logic             en_q,
  output logic [15:0]      base_q,
  output logic [IRQ_W-1:0] irq_q,
  output logic [7:0]       rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      base_q <= 16'h0000;
      irq_q  <= '0;
    end else if (wr_en) begin
      case (reg_num)
        RN_DEV_EN:  en_q         <= wdata[0];
        RN_BASE_HI: base_q[15:8] <= wdata;
        RN_BASE_LO: base_q[7:0]  <= wdata;
        RN_IRQ:     irq_q        <= wdata[IRQ_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_sel) begin
      case (reg_num)
        RN_DEV_EN:  rdata = {7'b0, en_q};
        RN_BASE_HI: rdata = base_q[15:8];
        RN_BASE_LO: rdata = base_q[7:0];
        RN_IRQ:     rdata = 8'(irq_q);
        default:    rdata = 8'h00;
      endcase
    end
  end

  // R10
  base_lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_num == RN_BASE_LO) |=> $stable(base_q[15:8]));

  // R8
  unselected_bank_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(base_q) && $stable(en_q) && $stable(irq_q)));

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
  import cfgport_pkg::*;
#(
  parameter int          NUM_LDEV  = 4,
  parameter int          IRQ_W     = 4,
  parameter logic [15:0] CHIP_ID   = 16'h1A2B,
  parameter logic [15:0] VENDOR_ID = 16'h3C4D,
  parameter logic [7:0]  KEY_ENTER = 8'h87,
  parameter logic [7:0]  KEY_EXIT  = 8'hAA
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      host_wr,
  input  logic                      host_rd,
  input  logic                      host_port,
  input  logic [7:0]                host_wdata,
  output logic [7:0]                host_rdata,
  output logic [NUM_LDEV-1:0]       dev_enable,
  output logic [16*NUM_LDEV-1:0]    dev_base,
  output logic [IRQ_W*NUM_LDEV-1:0] dev_irq
);

  logic       cfg_open;
  logic       idx_wr, dat_wr;
  logic [7:0] idx_q, ldsel_q;
  logic       glob_hit;
  logic [7:0] glob_rdata;
  logic [7:0] bank_rd [NUM_LDEV];
  logic [7:0] bank_or;

  assign idx_wr = host_wr && !host_port;
  assign dat_wr = host_wr &&  host_port;

  cfgport_unlock #(.KEY_ENTER(KEY_ENTER), .KEY_EXIT(KEY_EXIT)) u_unlock (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .dat_wr(dat_wr),
    .wdata(host_wdata), .cfg_open(cfg_open)
  );

  cfgport_global #(.CHIP_ID(CHIP_ID), .VENDOR_ID(VENDOR_ID), .KEY_EXIT(KEY_EXIT)) u_global (
    .clk(clk), .rst_n(rst_n), .cfg_open(cfg_open), .idx_wr(idx_wr),
    .dat_wr(dat_wr), .wdata(host_wdata), .idx_q(idx_q), .ldsel_q(ldsel_q),
    .glob_hit(glob_hit), .glob_rdata(glob_rdata)
  );

  for (genvar i = 0; i < NUM_LDEV; i++) begin : g_bank
    logic sel;
    assign sel = (ldsel_q == 8'(i));
    cfgport_bank #(.IRQ_W(IRQ_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_open && dat_wr && sel),
      .rd_sel(sel), .reg_num(idx_q), .wdata(host_wdata),
      .en_q(dev_enable[i]), .base_q(dev_base[16*i +: 16]),
      .irq_q(dev_irq[IRQ_W*i +: IRQ_W]), .rdata(bank_rd[i])
    );
  end

  always_comb begin
    bank_or = 8'h00;
    for (int k = 0; k < NUM_LDEV; k++) bank_or = bank_or | bank_rd[k];
  end

  always_comb begin
    if (!host_rd || !cfg_open) host_rdata = RD_FLOAT;
    else if (!host_port)       host_rdata = idx_q;
    else if (glob_hit)         host_rdata = glob_rdata;
    else                       host_rdata = bank_or;
  end

  // R4
  locked_reads_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && host_rd) |-> (host_rdata == RD_FLOAT));

  // R4
  locked_outputs_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> ($stable(dev_base) && $stable(dev_enable) && $stable(dev_irq)));

  // R11
  far_selector_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ldsel_q) >= NUM_LDEV) |=> ($stable(dev_base) && $stable(dev_enable) && $stable(dev_irq)));

endmodule

// File: tb/cfgport_top_test.sv
module cfgport_top_test;

  localparam int          CLK_PERIOD = 10;
  localparam int          NL   = 4;
  localparam int          IW   = 4;
  localparam logic [15:0] CHIP = 16'h1A2B;
  localparam logic [15:0] VEND = 16'h3C4D;
  localparam logic [7:0]  KIN  = 8'h87;
  localparam logic [7:0]  KOUT = 8'hAA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0, host_port = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic [NL-1:0]    dev_enable;
  logic [16*NL-1:0] dev_base;
  logic [IW*NL-1:0] dev_irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgport_top #(.NUM_LDEV(NL), .IRQ_W(IW), .CHIP_ID(CHIP), .VENDOR_ID(VEND),
                .KEY_ENTER(KIN), .KEY_EXIT(KOUT)) uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_port(host_port), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dev_enable(dev_enable), .dev_base(dev_base), .dev_irq(dev_irq)
  );

  // vector: {is_read, port, data, expected}
  localparam logic OPW = 1'b0, OPR = 1'b1, PI = 1'b0, PD = 1'b1;
  localparam int NV = 28;
  localparam logic [17:0] VEC [NV] = '{
    {OPW, PI, KIN,   8'h00}, {OPW, PI, KIN,   8'h00},
    {OPW, PI, 8'h20, 8'h00}, {OPR, PD, 8'h00, CHIP[15:8]},
    {OPW, PD, 8'h00, 8'h00}, {OPR, PD, 8'h00, CHIP[15:8]},
    {OPW, PI, 8'h21, 8'h00}, {OPR, PD, 8'h00, CHIP[7:0]},
    {OPW, PI, 8'h22, 8'h00}, {OPR, PD, 8'h00, VEND[15:8]},
    {OPW, PI, 8'h23, 8'h00}, {OPR, PD, 8'h00, VEND[7:0]},
    {OPW, PI, 8'h07, 8'h00}, {OPW, PD, 8'h01, 8'h00},
    {OPR, PD, 8'h00, 8'h01}, {OPR, PI, 8'h00, 8'h07},
    {OPW, PI, 8'h60, 8'h00}, {OPW, PD, 8'h12, 8'h00},
    {OPW, PI, 8'h61, 8'h00}, {OPW, PD, 8'h34, 8'h00},
    {OPW, PI, 8'h70, 8'h00}, {OPW, PD, 8'hF5, 8'h00},
    {OPR, PD, 8'h00, 8'h05}, {OPW, PI, 8'h30, 8'h00},
    {OPW, PD, 8'hFF, 8'h00}, {OPR, PD, 8'h00, 8'h01},
    {OPW, PI, 8'h61, 8'h00}, {OPR, PD, 8'h00, 8'h34}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic port, input logic [7:0] d);
    @(negedge clk);
    host_port = port; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic get(input logic port, output logic [7:0] q);
    @(negedge clk);
    host_port = port; host_rd = 1'b1;
    #1 q = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state, R4 locked reads
    check("R9 enable", 64'(dev_enable), 64'h0);
    check("R9 base",   64'(dev_base),   64'h0);
    check("R9 irq",    64'(dev_irq),    64'h0);
    get(PI, q); check("R4 locked index read", 64'(q), 64'hFF);
    check("R4 idle rdata", 64'(host_rdata), 64'hFF);

    // table: R1 unlock, R5 index, R6 ids, R7 selector, R8 bank fields
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][17]) begin
        get(VEC[v][16], q);
        check($sformatf("R5/R6/R7/R8 vector %0d", v), 64'(q), 64'(VEC[v][7:0]));
      end else begin
        put(VEC[v][16], VEC[v][15:8]);
      end
    end

    // R8 outputs of bank 1
    check("R8 base dev1", 64'(dev_base[16 +: 16]), 64'h1234);
    check("R8 irq dev1",  64'(dev_irq[IW +: IW]), 64'h5);
    check("R8 enable",    64'(dev_enable), 64'b0010);

    // R10 read-modify-write of base low byte
    get(PD, q);
    put(PD, q | 8'h80);
    get(PD, q); check("R10 rmw readback", 64'(q), 64'hB4);
    check("R10 base dev1", 64'(dev_base[16 +: 16]), 64'h12B4);
    check("R10 base dev0", 64'(dev_base[0 +: 16]), 64'h0000);

    // R8 enable only bit 0
    put(PI, 8'h30); put(PD, 8'h02);
    get(PD, q); check("R8 enable bit0 only", 64'(q), 64'h00);
    check("R8 enable cleared", 64'(dev_enable), 64'b0000);
    put(PD, 8'h01);

    // R11 selector out of range, unmapped register
    put(PI, 8'h07); put(PD, 8'h09);
    get(PD, q); check("R11 selector readback", 64'(q), 64'h09);
    put(PI, 8'h60);
    get(PD, q); check("R11 far bank read", 64'(q), 64'h00);
    put(PD, 8'h77);
    check("R11 far write ignored", 64'(dev_base), {16'h0, 16'h0, 16'h12B4, 16'h0});
    put(PI, 8'h55);
    get(PD, q); check("R11 unmapped read", 64'(q), 64'h00);
    put(PI, 8'h07); put(PD, 8'h01);

    // R3 exit key, R4 locked access
    put(PI, KOUT);
    get(PI, q); check("R3 locked after exit", 64'(q), 64'hFF);
    get(PD, q); check("R4 locked data read", 64'(q), 64'hFF);
    put(PD, 8'h5A);
    check("R4 locked write ignored", 64'(dev_base), {16'h0, 16'h0, 16'h12B4, 16'h0});

    // R1 single key does not open; read between keys keeps sequence
    put(PI, KIN);
    get(PD, q); check("R1 single key stays locked", 64'(q), 64'hFF);
    put(PI, KIN);
    get(PI, q); check("R3 index kept across exit", 64'(q), 64'h07);

    // R2 broken sequences
    put(PI, KOUT);
    put(PI, KIN); put(PI, 8'h11); put(PI, KIN);
    get(PI, q); check("R2 foreign index breaks key pair", 64'(q), 64'hFF);
    put(PD, 8'h55); put(PI, KIN);
    get(PI, q); check("R2 data write breaks key pair", 64'(q), 64'hFF);
    put(PI, KIN);
    get(PI, q); check("R5 index unchanged by locked writes", 64'(q), 64'h07);
    get(PD, q); check("R4 selector unchanged by locked write", 64'(q), 64'h01);

    // R9 reset again
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    check("R9 base after reset", 64'(dev_base), 64'h0);
    check("R9 enable after reset", 64'(dev_enable), 64'h0);
    get(PI, q); check("R9 locked after reset", 64'(q), 64'hFF);
    put(PI, KIN); put(PI, KIN);
    get(PI, q); check("R9 index cleared", 64'(q), 64'h00);
    put(PI, 8'h07);
    get(PD, q); check("R9 selector cleared", 64'(q), 64'h00);

    done = 1'b1;
    summary();
  end

endmodule